// File: doc/BRIEF.md
# Multilevel Interrupt Nesting Controller

This block keeps track of interrupt nesting across four priority classes: non-maskable, high, medium and low. Each class has a request line. A request is granted only when its class is strictly above every class that is already executing. The granted class then shows in a read-only status byte, and it stays there while higher classes preempt it. A return strobe retires the most recently entered handler. Because classes can only nest upward, that handler is always the highest class still flagged.

The block also gives the processor two fetch addresses, each chosen by its own configuration bit. The reset address is either zero or a boot base address. The vector table base is either a fixed offset from zero or the same offset above the boot base. Masking, arbitration among vectors inside one class, and saving the processor context are left to other logic.

Top module: `iv_nest_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the status byte reads 0x00.
- R2: Status bit 7 is the non-maskable flag, and bits 2, 1 and 0 are the high, medium and low flags. Bits 6 to 3 always read zero.
- R3: The grant output (bit 3 non-maskable, bit 2 high, bit 1 medium, bit 0 low) is combinational and has at most one bit set. It selects the highest requesting class that lies strictly above every set flag.
- R4: The flag of a granted class is set at the same clock edge, so it is visible from the next cycle on.
- R5: A flag that is already set stays set when a higher class is granted. Only a return can clear a flag.
- R6: A return strobe clears only the highest set flag, at the next clock edge.
- R7: A return strobe while no flag is set leaves the status byte unchanged.
- R8: A request of the same class as, or a lower class than, the highest set flag gets no grant and stays pending until that flag clears.
- R9: The reset address is 0 when boot_rst_sel is 1, and boot_base when it is 0.
- R10: The vector base is VEC_OFS (2) when vec_sel is 0, and boot_base + VEC_OFS when it is 1. It does not depend on boot_rst_sel.
- R11: When a return and a grant fall in the same cycle, the highest old flag is cleared and the granted flag is set at that one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 4 | Pending request per class (3 NMI, 2 high, 1 medium, 0 low) |
| ret_pulse | input | 1 | Return-from-interrupt strobe, one cycle |
| boot_rst_sel | input | 1 | 1: reset at address 0; 0: reset at boot_base |
| vec_sel | input | 1 | 1: vectors above boot_base; 0: vectors near address 0 |
| boot_base | input | ADDR_W | Boot section base address |
| irq_grant | output | 4 | One-hot grant for this cycle |
| status | output | 8 | Active-class status byte |
| reset_addr | output | ADDR_W | Selected reset address |
| vector_base | output | ADDR_W | Selected vector table base |

## Verification
If a flag is wrongly set or lost inside the block, the status byte shows the error in the very next cycle. A stuck or missing flag also changes the grant output in the same cycle as the next request: a stale high flag blocks grants that should happen, and a lost flag lets a same-class request through. The bench runs a behavioural model beside the design and compares the grant, the status byte and both addresses in every cycle. A corruption of the nesting stack is therefore reported no more than one cycle after it becomes visible.

// File: rtl/iv_pkg.sv
// Shared constants and helpers for the interrupt nesting controller.
// Assumes class index order: higher index means higher priority.
package iv_pkg;
    localparam int NUM_CLS = 4;
    localparam int CLS_NMI = 3;
    localparam int CLS_HI  = 2;
    localparam int CLS_MED = 1;
    localparam int CLS_LO  = 0;

    // Return a one-hot vector of the highest set bit (all zero if none).
    function automatic logic [NUM_CLS-1:0] top_onehot(input logic [NUM_CLS-1:0] v);
        logic [NUM_CLS-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_CLS; i++) begin
            if (v[i]) r = '0;
            if (v[i]) r[i] = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/iv_arbiter.sv
// Grant arbiter: picks the highest pending class strictly above all active
// classes. Purely combinational; assumes flags come from the nesting tracker.
module iv_arbiter
    import iv_pkg::*;
(
    input  logic [NUM_CLS-1:0] req,
    input  logic [NUM_CLS-1:0] flags,
    output logic [NUM_CLS-1:0] grant
);
    logic [NUM_CLS-1:0] blocked;
    logic [NUM_CLS-1:0] eligible;

    // Mark each class at or below the highest active class as blocked.
    always_comb begin
        for (int i = 0; i < NUM_CLS; i++) begin
            blocked[i] = |(flags >> i);
        end
        eligible = req & ~blocked;
        grant    = top_onehot(eligible);
    end
endmodule

// File: rtl/iv_nest_track.sv
// Nesting tracker: holds one active flag per class. Sets a flag on grant,
// clears the highest flag on return. Assumes grant is one-hot or zero.
module iv_nest_track
    import iv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CLS-1:0] grant,
    input  logic               ret_pulse,
    output logic [NUM_CLS-1:0] flags
);
    logic [NUM_CLS-1:0] clr_mask;

    // Select the flag retired by a return strobe.
    always_comb begin
        clr_mask = ret_pulse ? top_onehot(flags) : '0;
    end

    // Update the active flags with one clear and one set per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | grant;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));                                              // R3
    AST_GRANT_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (grant > flags));                            // R3
    AST_GRANT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> ((flags & $past(grant)) == $past(grant)));   // R4
    AST_KEEP_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_pulse |=> (($past(flags) & ~flags) == '0));               // R5
    AST_RET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pulse && flags != '0) |=> ($countones($past(flags) & ~flags) == 1)); // R6
    AST_RET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pulse && flags == '0 && grant == '0) |=> (flags == '0));  // R7
endmodule

// File: rtl/iv_vector_map.sv
// Address map: selects the reset address and vector base from two
// independent configuration bits. Assumes boot_base is quasi-static.
module iv_vector_map #(
    parameter int ADDR_W  = 16,
    parameter int VEC_OFS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_rst_sel,
    input  logic              vec_sel,
    input  logic [ADDR_W-1:0] boot_base,
    output logic [ADDR_W-1:0] reset_addr,
    output logic [ADDR_W-1:0] vector_base
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(VEC_OFS);

    // Choose the two fetch addresses.
    always_comb begin
        reset_addr  = boot_rst_sel ? '0 : boot_base;
        vector_base = vec_sel ? (boot_base + OFS) : OFS;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        boot_rst_sel |-> (reset_addr == '0));                          // R9
    AST_VEC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_sel |-> (vector_base == OFS));                            // R10
endmodule

// File: rtl/iv_nest_ctrl.sv
// Top of the multilevel interrupt nesting controller. Combines arbiter,
// tracker and address map, and packs the flags into the status byte.
// Assumes requests are held by their sources until granted.
module iv_nest_ctrl
    import iv_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int VEC_OFS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CLS-1:0]   irq_req,
    input  logic                 ret_pulse,
    input  logic                 boot_rst_sel,
    input  logic                 vec_sel,
    input  logic [ADDR_W-1:0]    boot_base,
    output logic [NUM_CLS-1:0]   irq_grant,
    output logic [7:0]           status,
    output logic [ADDR_W-1:0]    reset_addr,
    output logic [ADDR_W-1:0]    vector_base
);
    logic [NUM_CLS-1:0] flags;

    iv_arbiter u_arb (
        .req   (irq_req),
        .flags (flags),
        .grant (irq_grant)
    );

    iv_nest_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (irq_grant),
        .ret_pulse (ret_pulse),
        .flags     (flags)
    );

    iv_vector_map #(.ADDR_W(ADDR_W), .VEC_OFS(VEC_OFS)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_rst_sel (boot_rst_sel),
        .vec_sel      (vec_sel),
        .boot_base    (boot_base),
        .reset_addr   (reset_addr),
        .vector_base  (vector_base)
    );

    // Pack flags into the status byte; reserved bits read zero.
    always_comb begin
        status    = '0;
        status[7] = flags[CLS_NMI];
        status[2] = flags[CLS_HI];
        status[1] = flags[CLS_MED];
        status[0] = flags[CLS_LO];
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:3] == 4'b0);                                          // R2
endmodule

// File: tb/sim_iv_nest_ctrl.sv
module sim_iv_nest_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_req = '0;
    logic        ret_pulse = 1'b0;
    logic        boot_rst_sel = 1'b1;
    logic        vec_sel = 1'b0;
    logic [15:0] boot_base = 16'h8000;
    logic [3:0]  irq_grant;
    logic [7:0]  status;
    logic [15:0] reset_addr;
    logic [15:0] vector_base;

    int n_chk = 0;
    int n_bad = 0;
    int act[4];   // reference model: 1 if class active

    always #4 clk = ~clk;

    iv_nest_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ret_pulse(ret_pulse),
        .boot_rst_sel(boot_rst_sel), .vec_sel(vec_sel), .boot_base(boot_base),
        .irq_grant(irq_grant), .status(status), .reset_addr(reset_addr),
        .vector_base(vector_base)
    );

    function automatic int top_act();
        int t = -1;
        for (int i = 0; i < 4; i++) if (act[i] != 0) t = i;
        return t;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Drive one cycle of stimulus, compare all outputs, advance the model.
    task automatic step(input string tag, input logic [3:0] r, input logic rt);
        int th, g, es, ea, ev;
        @(negedge clk);
        irq_req = r;
        ret_pulse = rt;
        #1;
        th = top_act();
        g = -1;
        for (int i = 3; i >= 0; i--) if (g < 0 && r[i] && i > th) g = i;
        es = act[3] * 128 + act[2] * 4 + act[1] * 2 + act[0];
        ea = boot_rst_sel ? 0 : int'(boot_base);
        ev = vec_sel ? int'(16'(boot_base + 16'd2)) : 2;
        check("R3 grant", int'(irq_grant), (g < 0) ? 0 : (1 << g));
        check({tag, " status"}, int'(status), es);
        check("R9 reset_addr", int'(reset_addr), ea);
        check("R10 vector_base", int'(vector_base), ev);
        @(posedge clk);
        if (rt && th >= 0) act[th] = 0;
        if (g >= 0) act[g] = 1;
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) act[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 4'b0000, 1'b0);                // R1 reset state
        step("R7", 4'b0000, 1'b1);                // R7 return while idle
        step("R7", 4'b0000, 1'b0);
        // R4 R5 nest low -> medium -> high -> NMI
        step("R4", 4'b0001, 1'b0);
        step("R8", 4'b0001, 1'b0);                // R8 same class blocked
        step("R5", 4'b0010, 1'b0);
        step("R8", 4'b0011, 1'b0);
        step("R5", 4'b0100, 1'b0);
        step("R5", 4'b1000, 1'b0);
        step("R2", 4'b1111, 1'b0);                // R2 status 0x87
        // R6 unwind one level per return
        step("R6", 4'b0000, 1'b1);
        step("R6", 4'b0000, 1'b1);
        step("R6", 4'b0100, 1'b0);                // regrant high
        step("R11", 4'b1000, 1'b1);               // R11 return + grant
        step("R6", 4'b0000, 1'b1);
        step("R6", 4'b0000, 1'b1);
        step("R6", 4'b0000, 1'b1);
        step("R7", 4'b0000, 1'b1);
        // R9 R10 address selects in all combinations
        for (int c = 0; c < 4; c++) begin
            boot_rst_sel = c[0];
            vec_sel = c[1];
            boot_base = 16'hFFFE - 16'(c * 16'h1000);
            step("R9", 4'b0000, 1'b0);
        end
        boot_base = 16'hFFFF;                     // R10 wrap at top
        step("R10", 4'b0000, 1'b0);
        // random traffic compared against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] rr;
            logic       rt;
            rr = 4'($urandom);
            rr[3] = rr[3] & ($urandom_range(0, 3) == 0);
            rt = ($urandom_range(0, 2) == 0);
            if (k % 200 == 0) begin
                boot_rst_sel = 1'($urandom);
                vec_sel = 1'($urandom);
                boot_base = 16'($urandom);
            end
            step("R6", rr, rt);
        end
        // R1 reset while nested
        step("R4", 4'b0011, 1'b0);
        step("R4", 4'b0010, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        irq_req = '0;
        @(posedge clk);
        for (int i = 0; i < 4; i++) act[i] = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 4'b0000, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule